// File: doc/BRIEF.md
# SIMT Divergence Split/Join Stack

This block tracks branch divergence for a single warp. When a split strobe arrives, it compares the per-lane predicate with the current active-lane mask. If every active lane agrees, the block records one entry marked uniform and leaves the mask as it is. If the active lanes disagree, it pushes two entries and lets only the active lanes whose predicate is false keep running. Each later join pops one entry, restores the lane mask held in that entry, and may send the warp to a stored PC.

The upper entry of a divergent pair holds the taken lanes and the PC at the split, and it is not marked fall-through. Popping it therefore redirects fetch, so the taken path runs next. The lower entry holds the original mask and is marked fall-through. Popping it reconverges the warp at the next sequential PC. The stack depth, the lane count and the PC width are parameters.

The next mask and the redirect are combinational from the inputs and the top entry. The stack itself updates on the clock edge.

Top module: `simt_diverge_stack`

## Requirements
- R1: A split whose predicate bits agree over all active lanes, all ones or all zeros there, pushes exactly one entry marked uniform. In that cycle `mask_o` equals `mask_i`.
- R2: A non-uniform split drives `mask_o = mask_i & ~pred_i` in the same cycle.
- R3: A non-uniform split pushes two entries. The first join afterwards gives `mask_o = mask_i & pred_i` as it was at the split, with `pc_redir_o` = 1 and `pc_target_o` = the split PC. The second join gives the original mask with `pc_redir_o` = 0.
- R4: A join that pops a uniform entry restores that entry's mask with `pc_redir_o` = 0.
- R5: A split with `mask_i` all zero raises `err_o`, pushes nothing, and passes `mask_i` through.
- R6: A split that needs more free entries than remain raises `ovf_o`. The stack is left unchanged. A uniform split needs 1 free entry and a non-uniform split needs 2. The stack holds DEPTH entries.
- R7: A join on an empty stack raises `unf_o`, gives `pc_redir_o` = 0 and passes `mask_i` through.
- R8: `stall_o` is high for exactly the one cycle that follows a cycle with `split_i` high.
- R9: When `split_i` and `join_i` are both high, the split is performed and the join is ignored: no pop and no underflow.
- R10: After reset the stack is empty, `stall_o` is 0, and a join reports underflow.
- R11: Predicate bits on inactive lanes play no part in the uniform decision and do not appear in any mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_i | input | 1 | Split strobe |
| join_i | input | 1 | Join strobe |
| pred_i | input | LANES | Per-lane branch predicate |
| mask_i | input | LANES | Current active-lane mask |
| pc_i | input | PCW | PC of the split instruction |
| mask_o | output | LANES | Next active-lane mask |
| pc_redir_o | output | 1 | PC override valid |
| pc_target_o | output | PCW | PC override value |
| ovf_o | output | 1 | Split refused because the stack is full |
| unf_o | output | 1 | Join on an empty stack |
| err_o | output | 1 | Split with no active lanes |
| stall_o | output | 1 | One-slot issue stall after a split |

## Verification
The assertions take the strobes as single-cycle events. They expect `mask_i` to be held steady within a cycle, and they do not expect a join to arrive with any particular relation to earlier splits. The stimulus changes inputs only between clock edges, one operation per cycle. It covers every mask and predicate pair for a four-lane warp, each split followed by the joins needed to drain it. Separate phases fill the stack to its limit and assert both strobes together, so overflow and collision are seen only where the bench expects them.

// File: rtl/simt_diverge_stack.sv
module simt_diverge_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 8,
  parameter int PCW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             split_i,
  input  logic             join_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [PCW-1:0]   pc_i,
  output logic [LANES-1:0] mask_o,
  output logic             pc_redir_o,
  output logic [PCW-1:0]   pc_target_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             err_o,
  output logic             stall_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] mask_q [DEPTH];
  logic [PCW-1:0]   pc_q   [DEPTH];
  logic [DEPTH-1:0] uni_q, ft_q;
  logic [CW-1:0]    cnt_q;
  logic             stall_q;

  wire [LANES-1:0] taken    = pred_i & mask_i;
  wire             no_lanes = (mask_i == '0);
  wire             uniform  = (taken == '0) || (taken == mask_i);
  wire             empty    = (cnt_q == '0);
  wire             room1    = cnt_q < CW'(DEPTH);
  wire             room2    = cnt_q < CW'(DEPTH - 1);
  wire             do_split = split_i && !no_lanes;
  wire             push1    = do_split && uniform && room1;
  wire             push2    = do_split && !uniform && room2;
  wire             do_join  = join_i && !split_i;
  wire             pop      = do_join && !empty;

  wire [CW-1:0] top_c  = cnt_q - 1'b1;
  wire [IW-1:0] top    = top_c[IW-1:0];
  wire [CW-1:0] nxt_c  = cnt_q + 1'b1;
  wire [IW-1:0] wr0    = cnt_q[IW-1:0];
  wire [IW-1:0] wr1    = nxt_c[IW-1:0];

  always_comb begin
    mask_o = mask_i;
    if (push2)    mask_o = mask_i & ~pred_i;
    else if (pop) mask_o = mask_q[top];
  end

  assign pc_redir_o  = pop && !uni_q[top] && !ft_q[top];
  assign pc_target_o = pop ? pc_q[top] : pc_i;
  assign ovf_o       = do_split && (uniform ? !room1 : !room2);
  assign unf_o       = do_join && empty;
  assign err_o       = split_i && no_lanes;
  assign stall_o     = stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else begin
      stall_q <= split_i;
      if (push1)      cnt_q <= cnt_q + CW'(1);
      else if (push2) cnt_q <= cnt_q + CW'(2);
      else if (pop)   cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push1) begin
      mask_q[wr0] <= mask_i;
      pc_q[wr0]   <= pc_i;
      uni_q[wr0]  <= 1'b1;
      ft_q[wr0]   <= 1'b0;
    end else if (push2) begin
      mask_q[wr0] <= mask_i;
      pc_q[wr0]   <= pc_i;
      uni_q[wr0]  <= 1'b0;
      ft_q[wr0]   <= 1'b1;
      mask_q[wr1] <= taken;
      pc_q[wr1]   <= pc_i;
      uni_q[wr1]  <= 1'b0;
      ft_q[wr1]   <= 1'b0;
    end
  end

  p_uni_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && !err_o && ((pred_i & mask_i) == '0)) |-> (mask_o == mask_i));
  p_split_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && !err_o && !ovf_o && mask_o != mask_i) |-> ((mask_o & pred_i) == '0));
  p_redir_join_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redir_o |-> (join_i && !split_i));
  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (cnt_q == $past(cnt_q)));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == $past(cnt_q)));
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_unf_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> (!pc_redir_o && mask_o == mask_i));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    split_i |=> stall_o);
  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    split_i |-> !unf_o);
endmodule

// File: tb/simt_diverge_stack_bench.sv
`timescale 1ns/1ps
module simt_diverge_stack_bench;
  localparam int L = 4, D = 8;
  logic clk = 0, rst_n = 0;
  logic split_i = 0, join_i = 0;
  logic [L-1:0] pred_i = '0, mask_i = '0, mask_o;
  logic [31:0] pc_i = '0, pc_target_o;
  logic pc_redir_o, ovf_o, unf_o, err_o, stall_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  simt_diverge_stack #(.LANES(L), .DEPTH(D), .PCW(32)) u_simt_diverge_stack (
    .clk(clk), .rst_n(rst_n), .split_i(split_i), .join_i(join_i),
    .pred_i(pred_i), .mask_i(mask_i), .pc_i(pc_i), .mask_o(mask_o),
    .pc_redir_o(pc_redir_o), .pc_target_o(pc_target_o), .ovf_o(ovf_o),
    .unf_o(unf_o), .err_o(err_o), .stall_o(stall_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic j, input logic [L-1:0] m,
                       input logic [L-1:0] p, input logic [31:0] pc);
    @(negedge clk);
    split_i = s; join_i = j; mask_i = m; pred_i = p; pc_i = pc;
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    drive(0, 1, 4'h5, 0, 0);
    chk("R10 unf after reset", unf_o, 1);
    chk("R10 stall after reset", stall_o, 0);
    chk("R7 passthrough", mask_o, 4'h5);

    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [L-1:0] mm, tk;
        logic [31:0] pc;
        logic uni;
        mm = m[L-1:0];
        tk = mm & p[L-1:0];
        uni = (tk == 0) || (tk == mm);
        pc = 32'h1000 + 32'(m * 16 + p);
        drive(1, 0, mm, p[L-1:0], pc);
        if (mm == 0) begin
          chk("R5 err", err_o, 1);
          chk("R5 mask", mask_o, 0);
        end else if (uni) begin
          chk("R1 mask", mask_o, mm);
          chk("R11 no err", err_o, 0);
        end else begin
          chk("R2 mask", mask_o, mm & ~p[L-1:0]);
        end
        chk("R6 no ovf", ovf_o, 0);
        drive(0, 1, ~mm, 0, 0);
        chk("R8 stall", stall_o, 1);
        if (mm == 0) begin
          chk("R5 nothing pushed", unf_o, 1);
        end else if (uni) begin
          chk("R4 mask", mask_o, mm);
          chk("R4 redir", pc_redir_o, 0);
          drive(0, 1, ~mm, 0, 0);
          chk("R8 one cycle", stall_o, 0);
          chk("R1 single entry", unf_o, 1);
        end else begin
          chk("R3 taken mask", mask_o, tk);
          chk("R3 redir", pc_redir_o, 1);
          chk("R3 target", pc_target_o, pc);
          drive(0, 1, ~mm, 0, 0);
          chk("R3 reconverge mask", mask_o, mm);
          chk("R3 no redir", pc_redir_o, 0);
          drive(0, 1, ~mm, 0, 0);
          chk("R3 two entries", unf_o, 1);
        end
      end
    end

    for (int i = 0; i < D; i++) begin
      drive(1, 0, 4'hF, 4'h0, 32'(i));
      chk("R6 fill", ovf_o, 0);
    end
    drive(1, 0, 4'hF, 4'h0, 0);
    chk("R6 ovf uniform", ovf_o, 1);
    chk("R6 mask kept", mask_o, 4'hF);
    for (int i = 0; i < D; i++) begin
      drive(0, 1, 4'h0, 0, 0);
      chk("R6 drain", mask_o, 4'hF);
      chk("R6 drain unf", unf_o, 0);
    end
    drive(0, 1, 4'h0, 0, 0);
    chk("R6 state unchanged", unf_o, 1);

    for (int i = 0; i < D - 1; i++) drive(1, 0, 4'h3, 4'h3, 0);
    drive(1, 0, 4'hF, 4'h1, 32'h77);
    chk("R6 ovf divergent", ovf_o, 1);
    chk("R6 ovf mask", mask_o, 4'hF);
    drive(1, 0, 4'h3, 4'h0, 0);
    chk("R6 last slot", ovf_o, 0);
    for (int i = 0; i < D; i++) begin
      drive(0, 1, 4'h0, 0, 0);
      chk("R6 no divergent entry", pc_redir_o, 0);
    end
    drive(0, 1, 4'h0, 0, 0);
    chk("R6 empty", unf_o, 1);

    drive(1, 1, 4'hF, 4'h3, 32'hABC);
    chk("R9 no unf", unf_o, 0);
    chk("R9 split done", mask_o, 4'hC);
    drive(0, 1, 4'h0, 0, 0);
    chk("R9 taken", mask_o, 4'h3);
    chk("R9 target", pc_target_o, 32'hABC);
    drive(0, 1, 4'h0, 0, 0);
    chk("R9 reconverge", mask_o, 4'hF);
    drive(0, 1, 4'h0, 0, 0);
    chk("R9 drained", unf_o, 1);

    drive(1, 0, 4'h6, 4'h9, 0);
    chk("R11 inactive pred ignored", mask_o, 4'h6);
    drive(0, 1, 4'h0, 0, 0);
    chk("R11 uniform entry", pc_redir_o, 0);
    chk("R11 mask", mask_o, 4'h6);

    drive(0, 0, 4'h0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule